// File: doc/BRIEF.md
# Split-Timeout Control Register Pair

This block holds the two split-timeout control registers of a serial-bus node. One register counts whole seconds (the upper part) and the other counts bus cycles (the lower part). From both it derives a total timeout in bus cycles, which other logic on the node reads as a plain output. Software or a remote requester reaches the registers through a small port. Each register has its own write strobe, and there is one registered read strobe with a select.

Writes are made legal before they are stored. The seconds register keeps only the bits that fit. The cycles register takes its value from the top bits of the written word and forces that value into a legal window. Reads return each value in the same word position that a write uses. A reload strobe puts both registers back to their start-up values. This covers power-on initialisation and resume from a low-power state.

Top module: `split_timeout_regs`

## Requirements
- R1: While reset is asserted, `seconds` reads 0, `cycles` holds the reset-value parameter `LO_RESET` forced into the range `LO_MIN`..`LO_MAX`, `total_cycles` equals that cycles value, and `rd_data` is 0.
- R2: A seconds write (`wr_sec`) stores only `wr_data[2:0]`. The upper bits are dropped, so a written 8 stores 0.
- R3: A cycles write (`wr_cyc`) takes its raw value from `wr_data[31:19]`. Bits 18..0 of the written word have no effect.
- R4: A raw cycles value below 800 is stored as 800. The value 800 itself is stored unchanged.
- R5: A raw cycles value above 7999 is stored as 7999. The value 7999 itself is stored unchanged.
- R6: A read with `rd_cyc_sel`=1 returns the cycles value in bits 31..19, with bits 18..0 zero. A read with `rd_cyc_sel`=0 returns the seconds value in bits 2..0, with all other bits zero. The data appears on `rd_data` in the cycle after the `rd_en` edge.
- R7: `total_cycles` equals seconds × 8000 + cycles. It shows the new value in the cycle after any write or reload; the maximum is 63999.
- R8: `reload` sets seconds to 0 and cycles to the clamped reset value. If a write falls in the same cycle, `reload` wins over it.
- R9: A write to one register leaves the other unchanged. If both strobes arrive in the same cycle, both registers update from the same word.
- R10: In a cycle without `rd_en`, the next `rd_data` is 0. A read in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 1 | Restore start-up values (initialise/resume) |
| wr_sec | input | 1 | Write strobe, seconds register |
| wr_cyc | input | 1 | Write strobe, cycles register |
| wr_data | input | 32 | Write word shared by both strobes |
| rd_en | input | 1 | Read strobe |
| rd_cyc_sel | input | 1 | Read select: 1 cycles, 0 seconds |
| rd_data | output | 32 | Registered read word |
| total_cycles | output | 16 | Derived total timeout in bus cycles |

## Verification
The assertions assume `rst_n` is asserted long enough to load the start-up values. They also assume the strobes are clean levels, sampled at the rising edge, and never X. No assumption is made about combinations of strobes, so the stimulus deliberately overlaps writes, reads and reload in the same cycle. All inputs are driven at the falling edge, which keeps every strobe stable around the sampling edge. Write words carry random-looking junk in their ignored bits, so that a masking error shows up.

// File: rtl/spt_pkg.sv
package spt_pkg;

   // Force an integer into a closed range.
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction

endpackage

// File: rtl/spt_sec_reg.sv
module spt_sec_reg #(
   parameter int DATA_W = 32,
   parameter int HI_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [HI_W-1:0]   sec_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sec_q <= '0;
      else if (reload) sec_q <= '0;
      else if (wr)     sec_q <= wdata[HI_W-1:0];
   end

   assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !reload) |=> (sec_q == $past(wdata[HI_W-1:0])));

   assert_sec_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (sec_q == '0));

   assert_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !reload) |=> $stable(sec_q));

endmodule

// File: rtl/spt_cyc_reg.sv
module spt_cyc_reg #(
   parameter int DATA_W   = 32,
   parameter int LO_W     = 13,
   parameter int LO_MIN   = 800,
   parameter int LO_MAX   = 7999,
   parameter int LO_RESET = 800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [LO_W-1:0]   cyc_q
);

   localparam int            FIELD_MAX = (1 << LO_W) - 1;
   localparam logic [LO_W-1:0] MIN_V   = LO_W'(LO_MIN);
   localparam logic [LO_W-1:0] MAX_V   = LO_W'(LO_MAX);
   localparam logic [LO_W-1:0] RST_V   =
      LO_W'(spt_pkg::clamp_int(LO_RESET, LO_MIN, LO_MAX));

   logic [LO_W-1:0] raw;
   logic [LO_W-1:0] floor_v;
   logic [LO_W-1:0] legal_v;

   assign raw = wdata[DATA_W-1 -: LO_W];

   // Lower bound: skip the compare when the window starts at zero.
   generate
      if (LO_MIN == 0) begin : g_no_floor
         assign floor_v = raw;
      end else begin : g_floor
         assign floor_v = (raw < MIN_V) ? MIN_V : raw;
      end
   endgenerate

   // Upper bound: skip the compare when the window ends at the field top.
   generate
      if (LO_MAX == FIELD_MAX) begin : g_no_ceil
         assign legal_v = floor_v;
      end else begin : g_ceil
         assign legal_v = (floor_v > MAX_V) ? MAX_V : floor_v;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cyc_q <= RST_V;
      else if (reload) cyc_q <= RST_V;
      else if (wr)     cyc_q <= legal_v;
   end

   assert_cyc_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q >= MIN_V);

   assert_cyc_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q <= MAX_V);

   assert_cyc_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cyc_q == RST_V));

   assert_cyc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !reload) |=> $stable(cyc_q));

endmodule

// File: rtl/spt_total.sv
module spt_total #(
   parameter int HI_W    = 3,
   parameter int LO_W    = 13,
   parameter int CPS     = 8000,
   parameter int TOTAL_W = 16
) (
   input  logic [HI_W-1:0]    sec,
   input  logic [LO_W-1:0]    cyc,
   output logic [TOTAL_W-1:0] total
);

   localparam logic [TOTAL_W-1:0] CPS_V = TOTAL_W'(CPS);

   always_comb begin
      total = TOTAL_W'(sec) * CPS_V + TOTAL_W'(cyc);
   end

endmodule

// File: rtl/spt_read_port.sv
module spt_read_port #(
   parameter int DATA_W = 32,
   parameter int HI_W   = 3,
   parameter int LO_W   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rd_cyc_sel,
   input  logic [HI_W-1:0]   sec,
   input  logic [LO_W-1:0]   cyc,
   output logic [DATA_W-1:0] rd_data
);

   localparam int LO_SHIFT = DATA_W - LO_W;

   logic [DATA_W-1:0] sel_word;

   always_comb begin
      if (!rd_en)          sel_word = '0;
      else if (rd_cyc_sel) sel_word = {cyc, {LO_SHIFT{1'b0}}};
      else                 sel_word = DATA_W'(sec);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= sel_word;
   end

   assert_cyc_read_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_cyc_sel) |=> (rd_data[LO_SHIFT-1:0] == '0));

   assert_sec_read_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_cyc_sel) |=> (rd_data[DATA_W-1:HI_W] == '0));

   assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));

endmodule

// File: rtl/split_timeout_regs.sv
module split_timeout_regs #(
   parameter int DATA_W   = 32,
   parameter int HI_W     = 3,
   parameter int LO_W     = 13,
   parameter int LO_MIN   = 800,
   parameter int LO_MAX   = 7999,
   parameter int LO_RESET = 800,
   parameter int CPS      = 8000,
   parameter int TOTAL_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reload,
   input  logic               wr_sec,
   input  logic               wr_cyc,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic               rd_cyc_sel,
   output logic [DATA_W-1:0]  rd_data,
   output logic [TOTAL_W-1:0] total_cycles
);

   localparam int SEC_MAX   = (1 << HI_W) - 1;
   localparam int TOTAL_MAX = SEC_MAX * CPS + LO_MAX;

   generate
      if (HI_W + LO_W > DATA_W) begin : g_bad_fields
         $error("seconds and cycles fields overlap in the data word");
      end
      if (LO_MIN > LO_MAX) begin : g_bad_window
         $error("cycles window is empty");
      end
      if (LO_MAX >= (1 << LO_W)) begin : g_bad_max
         $error("cycles upper bound does not fit its field");
      end
      if (TOTAL_MAX >= (1 << TOTAL_W)) begin : g_bad_total
         $error("total output too narrow for the largest timeout");
      end
   endgenerate

   logic [HI_W-1:0] sec_q;
   logic [LO_W-1:0] cyc_q;

   spt_sec_reg #(.DATA_W(DATA_W), .HI_W(HI_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .reload(reload), .wr(wr_sec),
      .wdata(wr_data), .sec_q(sec_q)
   );

   spt_cyc_reg #(.DATA_W(DATA_W), .LO_W(LO_W), .LO_MIN(LO_MIN),
                 .LO_MAX(LO_MAX), .LO_RESET(LO_RESET)) u_cyc (
      .clk(clk), .rst_n(rst_n), .reload(reload), .wr(wr_cyc),
      .wdata(wr_data), .cyc_q(cyc_q)
   );

   spt_total #(.HI_W(HI_W), .LO_W(LO_W), .CPS(CPS), .TOTAL_W(TOTAL_W)) u_total (
      .sec(sec_q), .cyc(cyc_q), .total(total_cycles)
   );

   spt_read_port #(.DATA_W(DATA_W), .HI_W(HI_W), .LO_W(LO_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_cyc_sel(rd_cyc_sel),
      .sec(sec_q), .cyc(cyc_q), .rd_data(rd_data)
   );

   assert_total_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      total_cycles <= TOTAL_W'(TOTAL_MAX));

   assert_total_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sec && !wr_cyc && !reload) |=> $stable(total_cycles));

endmodule

// File: tb/split_timeout_regs_bench.sv
module split_timeout_regs_bench;

   localparam int RST_CYC = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reload = 1'b0;
   logic        wr_sec = 1'b0;
   logic        wr_cyc = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        rd_cyc_sel = 1'b0;
   logic [31:0] rd_data;
   logic [15:0] total_cycles;

   always #2 clk = ~clk;

   split_timeout_regs #(.LO_RESET(RST_CYC)) u_split_timeout_regs (
      .clk(clk), .rst_n(rst_n), .reload(reload), .wr_sec(wr_sec),
      .wr_cyc(wr_cyc), .wr_data(wr_data), .rd_en(rd_en),
      .rd_cyc_sel(rd_cyc_sel), .rd_data(rd_data), .total_cycles(total_cycles)
   );

   typedef struct {
      logic [31:0] rd;
      logic [15:0] tot;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   int    m_sec = 0;
   int    m_cyc = RST_CYC;
   bit    done  = 1'b0;

   function automatic int legal_cyc(input int v);
      if (v < 800)  return 800;
      if (v > 7999) return 7999;
      return v;
   endfunction

   // Driver: apply one cycle of stimulus and queue what must follow.
   task automatic op(input bit wh, input bit wl, input bit rl, input bit rd,
                     input bit sl, input logic [31:0] d, input string tag);
      item_t it;
      @(negedge clk);
      wr_sec = wh; wr_cyc = wl; reload = rl; rd_en = rd; rd_cyc_sel = sl; wr_data = d;
      if (!rd)     it.rd = '0;
      else if (sl) it.rd = 32'(m_cyc) << 19;
      else         it.rd = 32'(m_sec);
      if (rl) begin
         m_sec = 0;
         m_cyc = RST_CYC;
      end else begin
         if (wh) m_sec = int'(d[2:0]);
         if (wl) m_cyc = legal_cyc(int'(d[31:19]));
      end
      it.tot = 16'(m_sec * 8000 + m_cyc);
      it.tag = tag;
      q.push_back(it);
   endtask

   function automatic logic [31:0] cyc_word(input int v, input logic [18:0] junk);
      return {13'(v), junk};
   endfunction

   // Monitor: compare after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            n_cmp += 2;
            if (rd_data !== e.rd) begin
               n_bad++;
               $display("FAIL %s rd_data act=%h exp=%h", e.tag, rd_data, e.rd);
            end
            if (total_cycles !== e.tot) begin
               n_bad++;
               $display("FAIL %s total_cycles act=%0d exp=%0d", e.tag, total_cycles, e.tot);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      n_cmp += 2;
      if (rd_data !== 32'h0) begin
         n_bad++; $display("FAIL R1 rd_data act=%h exp=0", rd_data);
      end
      if (total_cycles !== 16'(RST_CYC)) begin
         n_bad++; $display("FAIL R1 total act=%0d exp=%0d", total_cycles, RST_CYC);
      end
      rst_n = 1'b1;

      op(0,0,0,1,0, 32'h0, "R1");                              // read seconds = 0
      op(0,0,0,1,1, 32'h0, "R1");                              // read cycles = reset
      op(1,0,0,0,0, 32'hFFFF_FFFB, "R2");                      // seconds <- 3
      op(0,0,0,1,0, 32'h0, "R2");
      op(1,0,0,1,0, 32'h0000_0008, "R2");                      // 8 -> 0, read old 3
      op(0,0,0,1,0, 32'h0, "R2");
      op(0,1,0,0,0, cyc_word(1234, 19'h5A5A5), "R3");
      op(0,0,0,1,1, 32'h0, "R3");
      op(0,1,0,0,0, cyc_word(10, 19'h7FFFF), "R4");
      op(0,0,0,1,1, 32'h0, "R4");
      op(0,1,0,0,0, cyc_word(799, 19'h0), "R4");
      op(0,1,0,1,1, cyc_word(800, 19'h1), "R4");
      op(0,1,0,0,0, cyc_word(8100, 19'h2), "R5");
      op(0,0,0,1,1, 32'h0, "R5");
      op(0,1,0,0,0, cyc_word(8191, 19'h3), "R5");
      op(0,1,0,0,0, cyc_word(7999, 19'h4), "R5");
      op(1,0,0,1,0, 32'h0000_0007, "R6");                      // R7 max total
      op(0,0,0,1,0, 32'h0, "R7");
      op(0,0,0,1,1, 32'h0, "R6");
      op(1,1,0,0,0, cyc_word(2500, 19'h0) | 32'h2, "R9");      // both at once
      op(0,0,0,1,0, 32'h0, "R9");
      op(0,1,0,1,0, cyc_word(3000, 19'h0) | 32'h5, "R9");      // seconds stays 2
      op(0,1,0,1,1, cyc_word(4000, 19'h0), "R10");             // read returns old
      op(0,0,0,0,1, 32'h0, "R10");                             // idle read = 0
      op(1,1,1,0,0, cyc_word(6000, 19'h0) | 32'h6, "R8");      // reload wins
      op(0,0,0,1,1, 32'h0, "R8");
      op(0,0,0,1,0, 32'h0, "R8");
      op(0,0,0,0,0, 32'h0, "R10");

      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule